// File: doc/BRIEF.md
# Affinity-Routed Software Interrupt Request Decoder

This block turns a 64-bit software interrupt request word into pending flags for a fixed set of processing elements (PEs). Each PE has a static four-level affinity address built into the block. A request names one of 16 software interrupt identifiers. It then selects its targets in one of two ways. In the first, it gives a cluster address and a 16-bit target bitmap, and the bitmap is moved up the lowest affinity level by a range selector. In the second, it sends the interrupt to every PE except the one making the request.

A PE that issues the write supplies its own index together with the write strobe. Each write is decoded on its own. A requester whose targets span several clusters therefore issues one write per cluster, and the pending flags accumulate. Each pending flag stays set until its per-PE, per-identifier clear input is pulsed.

Top module: `sgi_affinity_router`

## Requirements
- R1: The identifier is taken from word bits [27:24]. A write sets only that identifier's flag in each targeted PE, and pend_o bit p*16+id is PE p, identifier id.
- R2: In targeted mode, target bit n (word bits [15:0]) selects the PE whose lowest affinity byte equals rs*16+n. Here rs is word bits [47:44].
- R3: In targeted mode, a PE is hit only if its second, third and top affinity bytes equal word bits [23:16], [39:32] and [55:48] respectively.
- R4: When word bit 40 is 1, all PEs except the one indexed by req_pe_i are targeted, and the bitmap, range selector and affinity fields are ignored.
- R5: A write sets its flags on the clock edge that samples req_valid_i, and not before.
- R6: A clear and a set of the same flag on the same edge leave the flag set.
- R7: A clear pulse drops only its own flag on that edge, and all other flags are unaffected.
- R8: Target bits that match no existing PE are dropped, and no flag changes for them.
- R9: After reset every pending flag is 0.
- R10: Successive writes OR into the pending flags, so one write per cluster reaches PEs in several clusters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Write strobe for the request word |
| req_word_i | input | 64 | Request word |
| req_pe_i | input | PE_IDX_W | Index of the requesting PE |
| clr_i | input | NUM_PE*16 | Per-PE, per-identifier clear pulses |
| pend_o | output | NUM_PE*16 | Registered pending flags |

## Verification
The bench aims at the range-selector offset. A full bitmap with rs=0 must not reach the PE whose lowest affinity byte is 17, while rs=1 with bit 1 must reach it. A decoder that ignored rs would flag both cases, and one that mis-shifted the offset would flag neither. The bench also checks that each single mismatched upper affinity byte suppresses delivery. It checks that broadcast mode skips only the requester even when junk sits in the ignored fields, that a clear arriving together with a set loses, and that bitmap bits aimed at absent PEs leave every flag at zero.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned NUM_ID   = 16;
  localparam int unsigned ID_W     = 4;
  localparam int unsigned TL_W     = 16;
  localparam int unsigned AFF_W    = 8;
  localparam int unsigned RS_W     = 4;
  localparam int unsigned WORD_W   = 64;

  typedef struct packed {
    logic [AFF_W-1:0] aff3;
    logic [AFF_W-1:0] aff2;
    logic [AFF_W-1:0] aff1;
    logic [AFF_W-1:0] aff0;
  } pe_aff_t;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [TL_W-1:0]  tlist;
    logic [AFF_W-1:0] aff1;
    logic [AFF_W-1:0] aff2;
    logic [AFF_W-1:0] aff3;
    logic [RS_W-1:0]  rsel;
    logic             bcast;
  } sgi_req_t;
endpackage

// File: rtl/sgi_field_decode.sv
module sgi_field_decode
  import sgi_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output sgi_req_t          req_o,
  output logic [NUM_ID-1:0] id_oh_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[63:56], word_i[43:41], word_i[31:28]};

  always_comb begin
    req_o.tlist = word_i[15:0];
    req_o.aff1  = word_i[23:16];
    req_o.id    = word_i[27:24];
    req_o.aff2  = word_i[39:32];
    req_o.bcast = word_i[40];
    req_o.rsel  = word_i[47:44];
    req_o.aff3  = word_i[55:48];
  end

  always_comb begin
    id_oh_o = '0;
    id_oh_o[req_o.id] = 1'b1;
  end

  always_comb assert ($onehot(id_oh_o)) else $error("p_id_onehot_r1");
endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_PE = 4,
  parameter logic [NUM_PE*32-1:0] PE_AFF = '0,
  localparam int unsigned PE_IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  sgi_req_t            req_i,
  input  logic [PE_IDX_W-1:0] req_pe_i,
  output logic [NUM_PE-1:0]   hit_o
);
  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    pe_aff_t aff;
    logic    grp_ok, slot_ok;
    assign aff     = pe_aff_t'(PE_AFF[p*32 +: 32]);
    // bitmap covers aff0 = rsel*16 .. rsel*16+15
    assign grp_ok  = (aff.aff3 == req_i.aff3) && (aff.aff2 == req_i.aff2) &&
                     (aff.aff1 == req_i.aff1) && (aff.aff0[7:4] == req_i.rsel);
    assign slot_ok = req_i.tlist[aff.aff0[3:0]];
    always_comb begin
      if (!valid_i)          hit_o[p] = 1'b0;
      else if (req_i.bcast)  hit_o[p] = (PE_IDX_W'(p) != req_pe_i);
      else                   hit_o[p] = grp_ok && slot_ok;
    end
  end

  p_bcast_skips_self_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && req_i.bcast && (32'(req_pe_i) < NUM_PE)) |-> !hit_o[req_pe_i]);

  p_bcast_others_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && req_i.bcast) |-> ($countones(hit_o) >= NUM_PE - 1));

  p_idle_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (hit_o == '0));
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
  import sgi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_ID-1:0] set_i,
  input  logic [NUM_ID-1:0] clr_i,
  output logic [NUM_ID-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;  // set wins
  end

  p_one_id_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_i));

  for (genvar k = 0; k < NUM_ID; k++) begin : g_chk
    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_o[k]);
    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !set_i[k]) |=> $stable(pend_o[k]));
  end
endmodule

// File: rtl/sgi_affinity_router.sv
module sgi_affinity_router
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_PE = 4,
  // PE p affinity at [p*32 +: 32] as {aff3, aff2, aff1, aff0}
  parameter logic [NUM_PE*32-1:0] PE_AFF = 128'h00000011_00000100_00000001_00000000,
  localparam int unsigned PE_IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int unsigned PEND_W   = NUM_PE * NUM_ID
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [WORD_W-1:0]   req_word_i,
  input  logic [PE_IDX_W-1:0] req_pe_i,
  input  logic [PEND_W-1:0]   clr_i,
  output logic [PEND_W-1:0]   pend_o
);
  sgi_req_t          req;
  logic [NUM_ID-1:0] id_oh;
  logic [NUM_PE-1:0] hit;

  sgi_field_decode u_dec (
    .word_i  (req_word_i),
    .req_o   (req),
    .id_oh_o (id_oh)
  );

  sgi_target_match #(.NUM_PE(NUM_PE), .PE_AFF(PE_AFF)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .req_i    (req),
    .req_pe_i (req_pe_i),
    .hit_o    (hit)
  );

  for (genvar p = 0; p < NUM_PE; p++) begin : g_bank
    logic [NUM_ID-1:0] set;
    assign set = hit[p] ? id_oh : '0;
    sgi_pend_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set),
      .clr_i  (clr_i[p*NUM_ID +: NUM_ID]),
      .pend_o (pend_o[p*NUM_ID +: NUM_ID])
    );
  end

  p_quiet_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && clr_i == '0) |=> $stable(pend_o));
endmodule

// File: tb/sgi_affinity_router_bench.sv
module sgi_affinity_router_bench;
  localparam int NV = 11;
  // PEs: 0={0,0,0,0} 1={0,0,0,1} 2={0,0,1,0} 3={0,0,0,17}
  localparam logic [63:0] V_WORD [NV] = '{
    64'h0000_0000_0500_0003,  // R1 R2 id5 to PE0,PE1
    64'h0000_0000_0301_0001,  // R3 aff1=1 -> PE2
    64'h0000_1000_0F00_0002,  // R2 rs=1 bit1 -> PE3 (aff0 17)
    64'h00AA_0100_0700_FFFF,  // R4 broadcast, junk fields, req PE1
    64'h0000_0001_0200_0003,  // R3 aff2 mismatch
    64'h0001_0000_0200_0003,  // R3 aff3 mismatch
    64'h0000_0000_0100_FFFC,  // R8 bits to absent PEs
    64'h0000_0000_0000_FFFF,  // R2 rs=0 must not reach aff0 17
    64'h0000_0100_0000_0000,  // R4 broadcast, req PE0
    64'h0000_2000_0400_FFFF,  // R8 rs=2, nobody
    64'h0000_1000_0601_FFFF   // R8 R3 aff1=1 rs=1, nobody
  };
  localparam logic [1:0] V_PE [NV] = '{2'd0,2'd0,2'd0,2'd1,2'd0,2'd0,2'd0,2'd0,2'd0,2'd3,2'd0};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000_0000_0020_0020, 64'h0000_0008_0000_0000, 64'h8000_0000_0000_0000,
    64'h0080_0080_0000_0080, 64'h0, 64'h0, 64'h0,
    64'h0000_0000_0001_0001, 64'h0001_0001_0001_0000, 64'h0, 64'h0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [63:0] word = '0;
  logic [1:0]  pe = '0;
  logic [63:0] clr = '0;
  logic [63:0] pend;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sgi_affinity_router u_sgi_affinity_router (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_word_i(word),
    .req_pe_i(pe), .clr_i(clr), .pend_o(pend)
  );

  task automatic check(input string req, input logic [63:0] exp);
    nchk++;
    if (pend !== exp) begin
      nfail++;
      $display("FAIL %s: pend=%h expected=%h", req, pend, exp);
    end
  endtask

  task automatic write(input logic [63:0] w, input logic [1:0] p);
    @(negedge clk); word = w; pe = p; valid = 1'b1;
    @(negedge clk); valid = 1'b0; word = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", 64'h0);

    for (int i = 0; i < NV; i++) begin
      clear_all();
      write(V_WORD[i], V_PE[i]);
      check($sformatf("R1-table vector %0d", i), V_EXP[i]);
    end

    // R5: not visible before the sampling edge
    clear_all();
    @(negedge clk); word = 64'h0000_0000_0500_0003; pe = 0; valid = 1'b1;
    #1 check("R5 before edge", 64'h0);
    @(negedge clk); valid = 1'b0;
    check("R5 after edge", 64'h0000_0000_0020_0020);

    // R10: accumulate across clusters
    clear_all();
    write(64'h0000_0000_0900_0002, 2'd0);
    write(64'h0000_0000_0901_0001, 2'd0);
    check("R10 two clusters", 64'h0000_0200_0200_0000);

    // R7: clear one flag only
    @(negedge clk); clr = 64'h0000_0200_0000_0000;
    @(negedge clk); clr = '0;
    check("R7 single clear", 64'h0000_0000_0200_0000);

    // R6: clear and set together
    @(negedge clk); word = 64'h0000_0000_0900_0002; pe = 0; valid = 1'b1;
    clr = 64'h0000_0000_0200_0000;
    @(negedge clk); valid = 1'b0; clr = '0;
    check("R6 set beats clear", 64'h0000_0000_0200_0000);

    // R8: broadcast from absent-free idle keeps state; idle no change
    repeat (3) @(negedge clk);
    check("R5 idle hold", 64'h0000_0000_0200_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: pend=%h expected=done", pend);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule